// File: doc/BRIEF.md
# Receive Fragment Descriptor DMA Engine

This block takes a stream of received Ethernet frame bytes, already stripped of preamble and already filtered, and stores each frame in memory across a circular ring of receive descriptors. Each descriptor supplies a buffer base address, a buffer length stored as length minus one, and a flag that asks for an interrupt. The engine writes payload bytes one at a time to a memory write port with a valid/ready handshake. When a buffer fills or the frame ends, it writes one status word for that fragment.

Software owns the consume index and the descriptor table. The engine owns the produce index, which it presents as the lookup index into the table. One slot of the ring always stays empty, so an empty ring and a full ring can be told apart. A frame that cannot be placed because the ring is full is dropped and recorded in a sticky overrun flag. Reception is gated by an enable input and starts only at a frame start seen while enabled. A receive-done interrupt pulses after a status word has been accepted by memory, if that descriptor asked for one.

Top module: `rx_frag_dma`

## Requirements
- R1: After reset, prod_idx is 0, mem_valid is low, irq_done is low, overrun is low and in_ready is high.
- R2: The ring is full when the successor of prod_idx (wrapping after DEPTH-1) equals cons_idx. A new fragment is never started while the ring is full. With DEPTH = 4 and both indices at 0, at most three descriptors are filled.
- R3: When software advances cons_idx, by more than one in a single step if it likes, the engine places the next frame in the descriptor at prod_idx.
- R4: A data write has mem_stat = 0, address desc_base + offset-within-buffer, and the byte in mem_wdata[7:0] with the upper bits zero. A status write has mem_stat = 1, address STAT_BASE + 4*prod_idx, mem_wdata[31] as the last-fragment flag, mem_wdata[SW-1:0] as the fragment byte count minus one, and all other bits zero.
- R5: If a frame is longer than the current buffer, the buffer is filled completely (desc_size_m1 + 1 bytes), its status is written with the last flag set to 0, and the frame continues at offset 0 of the next descriptor.
- R6: The fragment that holds a frame's final byte gets a status with the last flag set to 1. The next frame always starts at offset 0 of a new descriptor.
- R7: Bytes are ignored while rx_en is low. A frame whose start byte arrived while rx_en was low is discarded completely, even if rx_en rises partway through it. Reception resumes at the next start byte.
- R8: irq_done pulses high for one cycle, in the cycle after a status write is accepted, exactly when desc_irq was set for that descriptor. It never pulses otherwise.
- R9: prod_idx advances by one, wrapping to 0 after DEPTH-1, each time a status write is accepted, and changes at no other time.
- R10: A pending write holds its address, data and kind until mem_ready is sampled high. A fragment's status is issued only after its last data write is accepted. in_ready is low while a write is pending.
- R11: If a byte needs a new descriptor while the ring is full, the rest of that frame is dropped with no further writes and no status for the unfinished fragment, and overrun is set and stays set until reset.
- R12: A 19-byte frame received into descriptors with 8-byte buffers produces three status writes with counts 7, 7, 2 and last flags 0, 0, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enable |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first of a frame |
| in_eop | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine can take an input byte |
| cons_idx | input | IW | Consume index written by software |
| prod_idx | output | IW | Produce index, also the descriptor lookup index |
| desc_base | input | AW | Buffer base address of descriptor prod_idx |
| desc_size_m1 | input | SW | Buffer length minus one of descriptor prod_idx |
| desc_irq | input | 1 | Interrupt request flag of descriptor prod_idx |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_stat | output | 1 | Write carries a status word (1) or a data byte (0) |
| mem_addr | output | AW | Write address |
| mem_wdata | output | 32 | Write data |
| irq_done | output | 1 | Receive-done interrupt pulse |
| overrun | output | 1 | Sticky flag for a frame dropped on a full ring |

## Verification
The worked case is a 19-byte frame over 8-byte buffers. It shows whether the minus-one size encoding, the spill across buffers and the last-fragment flag agree. Directed runs then drive the ring to full, both at a frame start and in the middle of a frame, to separate a correct one-empty-slot rule from an off-by-one. They also check that a dropped frame leaves no stray status. A frame that starts while the engine is disabled shows whether enable gating acts at frame boundaries or at byte boundaries. Random frame lengths, buffer sizes, interrupt flags, consume advances, input gaps and memory stalls are then compared write by write against a bench model. This shows whether addresses, wrap-around and interrupt pairing stay correct under backpressure.

// File: rtl/rx_frag_dma.sv
module rx_frag_dma #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int SW = 11,
  parameter int STAT_BASE = 32'h0000_F000,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic [IW-1:0] cons_idx,
  output logic [IW-1:0] prod_idx,
  input  logic [AW-1:0] desc_base,
  input  logic [SW-1:0] desc_size_m1,
  input  logic          desc_irq,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_stat,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          irq_done,
  output logic          overrun
);

  typedef enum logic [2:0] {S_IDLE, S_FRAME, S_WDATA, S_WSTAT, S_DROP} st_t;

  st_t           st;
  logic [SW-1:0] offs;
  logic [7:0]    byte_q;
  logic          last_q;

  wire [IW-1:0] prod_nx = (prod_idx == IW'(DEPTH - 1)) ? '0 : prod_idx + 1'b1;
  wire ring_full = (prod_nx == cons_idx);
  wire no_room   = (offs == '0) && ring_full;
  wire take      = in_valid && in_ready;
  wire buf_end   = (offs == desc_size_m1);

  assign in_ready  = (st == S_IDLE) || (st == S_FRAME) || (st == S_DROP);
  assign mem_valid = (st == S_WDATA) || (st == S_WSTAT);
  assign mem_stat  = (st == S_WSTAT);
  assign mem_addr  = mem_stat ? AW'(STAT_BASE) + AW'({prod_idx, 2'b00})
                              : desc_base + AW'(offs);
  assign mem_wdata = mem_stat ? {last_q, {(31 - SW){1'b0}}, offs}
                              : {24'b0, byte_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      offs     <= '0;
      byte_q   <= '0;
      last_q   <= 1'b0;
      prod_idx <= '0;
      irq_done <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      case (st)
        S_IDLE, S_FRAME: begin
          if (take && (st == S_FRAME || (in_sop && rx_en))) begin
            if (no_room) begin
              overrun <= 1'b1;
              st      <= in_eop ? S_IDLE : S_DROP;
            end else begin
              byte_q <= in_data;
              last_q <= in_eop;
              st     <= S_WDATA;
            end
          end
        end
        S_WDATA: begin
          if (mem_ready) begin
            if (last_q || buf_end) begin
              st <= S_WSTAT;
            end else begin
              offs <= offs + 1'b1;
              st   <= S_FRAME;
            end
          end
        end
        S_WSTAT: begin
          if (mem_ready) begin
            prod_idx <= prod_nx;
            offs     <= '0;
            irq_done <= desc_irq;
            st       <= last_q ? S_IDLE : S_FRAME;
          end
        end
        S_DROP: begin
          if (take && in_eop) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_frag_dma_chk.sv
module rx_frag_dma_chk #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_stat,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [IW-1:0] prod_idx,
  input logic [IW-1:0] cons_idx,
  input logic          irq_done,
  input logic          overrun
);

  function automatic logic [IW-1:0] nx(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_stat)); // R10

  AST_NO_INPUT_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !in_ready); // R10

  AST_IRQ_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> $past(mem_valid && mem_ready && mem_stat)); // R8

  AST_PROD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_idx != $past(prod_idx)) |-> (prod_idx == nx($past(prod_idx))) && $past(mem_valid && mem_ready && mem_stat)); // R9

  AST_NO_FILL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_stat |-> nx(prod_idx) != cons_idx); // R2

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R11

endmodule

bind rx_frag_dma rx_frag_dma_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_stat(mem_stat), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .prod_idx(prod_idx), .cons_idx(cons_idx),
  .irq_done(irq_done), .overrun(overrun)
);

// File: tb/tb_rx_frag_dma.sv
module tb_rx_frag_dma;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int SW = 11;
  localparam int STAT = 32'h0000_F000;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic [IW-1:0] cons_idx = '0, prod_idx;
  logic [AW-1:0] desc_base;
  logic [SW-1:0] desc_size_m1;
  logic desc_irq;
  logic mem_valid, mem_ready = 1'b0, mem_stat;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic irq_done, overrun;

  logic [AW-1:0] t_base [DEPTH];
  logic [SW-1:0] t_size [DEPTH];
  logic          t_irq  [DEPTH];
  assign desc_base    = t_base[prod_idx];
  assign desc_size_m1 = t_size[prod_idx];
  assign desc_irq     = t_irq[prod_idx];

  rx_frag_dma #(.DEPTH(DEPTH), .AW(AW), .SW(SW), .STAT_BASE(STAT)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .in_ready(in_ready), .cons_idx(cons_idx),
    .prod_idx(prod_idx), .desc_base(desc_base), .desc_size_m1(desc_size_m1),
    .desc_irq(desc_irq), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_stat(mem_stat), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .irq_done(irq_done), .overrun(overrun)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [AW-1:0] q_addr [$];
  logic [31:0]   q_data [$];
  logic          q_stat [$];
  logic [31:0]   seen_stat [$];
  int  exp_prod = 0, exp_irq_total = 0, irq_count = 0;
  bit  exp_ovr = 0, irq_exp = 0, stall_mem = 0;
  logic [7:0] fr [64];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int nxf(input int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      mem_ready = !stall_mem && (($urandom % 4) != 0);
      if (irq_done || irq_exp) chk(irq_done == irq_exp, "R8", "irq pulse", irq_done, irq_exp);
      if (irq_done) irq_count++;
      irq_exp = 0;
      if (mem_valid && mem_ready) begin
        if (q_addr.size() == 0) begin
          chk(0, "R10", "unexpected write addr", mem_addr, 0);
        end else begin
          logic [AW-1:0] ea; logic [31:0] ed; logic es;
          ea = q_addr.pop_front(); ed = q_data.pop_front(); es = q_stat.pop_front();
          chk(mem_stat == es, "R4", "write kind", mem_stat, es);
          chk(mem_addr == ea, es ? "R4" : "R5", "write addr", mem_addr, ea);
          chk(mem_wdata == ed, es ? "R6" : "R4", "write data", mem_wdata, ed);
        end
        if (mem_stat) begin
          seen_stat.push_back(mem_wdata);
          irq_exp = t_irq[prod_idx];
        end
      end
    end
  end

  task automatic model_frame(input int len);
    int p = exp_prod, off = 0;
    bit drop = 0;
    for (int i = 0; i < len; i++) begin
      if (!drop) begin
        if (off == 0 && nxf(p) == int'(cons_idx)) begin
          exp_ovr = 1; drop = 1;
        end else begin
          q_addr.push_back(t_base[p] + AW'(off));
          q_data.push_back({24'b0, fr[i]});
          q_stat.push_back(1'b0);
          if (off == int'(t_size[p]) || i == len - 1) begin
            q_addr.push_back(AW'(STAT + 4 * p));
            q_data.push_back({(i == len - 1), 31'(off)});
            q_stat.push_back(1'b1);
            if (t_irq[p]) exp_irq_total++;
            p = nxf(p); off = 0;
          end else off++;
        end
      end
    end
    exp_prod = p;
  endtask

  task automatic send_frame(input int len, input int en_after, input bit modeled);
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    if (modeled) model_frame(len);
    for (int i = 0; i < len; i++) begin
      if (i == en_after) rx_en = 1'b1;
      in_valid = 1'b1; in_data = fr[i]; in_sop = (i == 0); in_eop = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic settle(input string rq);
    int t = 0;
    while (q_addr.size() != 0 && t < 400) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(q_addr.size() == 0, rq, "writes outstanding", q_addr.size(), 0);
    chk(prod_idx == IW'(exp_prod), "R9", "produce index", prod_idx, exp_prod);
    chk(overrun == exp_ovr, "R11", "overrun flag", overrun, exp_ovr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin
      t_base[i] = AW'(i * 16'h100); t_size[i] = SW'(7); t_irq[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    chk(prod_idx == '0, "R1", "reset prod_idx", prod_idx, 0);
    chk(!mem_valid, "R1", "reset mem_valid", mem_valid, 0);
    chk(!irq_done, "R1", "reset irq_done", irq_done, 0);
    chk(!overrun, "R1", "reset overrun", overrun, 0);
    chk(in_ready, "R1", "reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;

    // R12 worked case with R5, R6
    seen_stat.delete();
    send_frame(19, -1, 1);
    settle("R12");
    chk(seen_stat.size() == 3, "R12", "status count", seen_stat.size(), 3);
    if (seen_stat.size() == 3) begin
      chk(seen_stat[0] == 32'h0000_0007, "R12", "status 0", seen_stat[0], 32'h7);
      chk(seen_stat[1] == 32'h0000_0007, "R12", "status 1", seen_stat[1], 32'h7);
      chk(seen_stat[2] == 32'h8000_0002, "R12", "status 2", seen_stat[2], 32'h8000_0002);
    end
    chk(prod_idx == 2'd3, "R2", "three slots used", prod_idx, 3);

    // R2/R11: ring full, frame dropped
    send_frame(5, -1, 1);
    settle("R11");
    chk(overrun == 1'b1, "R11", "overrun after full", overrun, 1);
    chk(prod_idx == 2'd3, "R2", "no fill while full", prod_idx, 3);

    // R3: consume advanced by three at once
    @(negedge clk); cons_idx = 2'd3;
    send_frame(10, -1, 1);
    settle("R3");
    chk(prod_idx == 2'd1, "R3", "resume after advance", prod_idx, 1);

    // R7: disabled bytes and a frame started before enable
    @(negedge clk); cons_idx = 2'd1; rx_en = 1'b0;
    send_frame(4, 99, 0);
    send_frame(6, 3, 0);
    settle("R7");
    chk(prod_idx == 2'd1, "R7", "pre-enable frame dropped", prod_idx, 1);
    send_frame(4, -1, 1);
    settle("R7");

    // R8: descriptors without interrupt, R11 mid-frame overrun
    for (int i = 0; i < DEPTH; i++) t_irq[i] = 1'b0;
    @(negedge clk); cons_idx = IW'(nxf(nxf(int'(prod_idx))));
    send_frame(12, -1, 1);
    settle("R11");

    // random phase
    stall_mem = 0;
    for (int f = 0; f < 60; f++) begin
      int used, adv;
      used = (int'(prod_idx) - int'(cons_idx) + DEPTH) % DEPTH;
      adv = (used == 0) ? 0 : ($urandom % (used + 1));
      @(negedge clk);
      cons_idx = IW'((int'(cons_idx) + adv) % DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
        t_size[i] = SW'($urandom % 12);
        t_irq[i]  = 1'($urandom);
      end
      send_frame(1 + ($urandom % 30), -1, 1);
      settle("R5");
    end

    // R10: memory stalled holds the engine
    @(negedge clk); cons_idx = prod_idx; stall_mem = 1;
    fork send_frame(3, -1, 1); join_none
    repeat (20) @(negedge clk);
    chk(mem_valid && !in_ready, "R10", "stall holds write", {mem_valid, in_ready}, 2'b10);
    stall_mem = 0;
    wait fork;
    settle("R10");
    chk(irq_count == exp_irq_total, "R8", "interrupt count", irq_count, exp_irq_total);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule